// File: doc/BRIEF.md
# DRAM Multipurpose Register Readout

This block sits on the DRAM side of a command decoder. It tracks the mode register 3 field that steers reads away from the memory array and toward a fixed calibration source. While that steering is on, each valid READ or read-with-auto-precharge (RDAP) command produces a burst of alternating 0/1 beats on the DQ lanes after a fixed read latency. A controller uses these bursts to align its read capture window before normal traffic begins. While the mode is on, every other command is rejected with a one-cycle error pulse. The only exception is a well-formed mode register 3 load, which is how the mode is left.

The burst length comes from a small copy of the mode register 0 burst field. It can be a fixed 8-beat burst, a fixed 4-beat chop, or a per-command choice made through address bit 12. A build-time parameter picks the lane mapping. In the prime-lane build, only lane 0 carries the pattern, plus lane 8 on 16-bit parts, and every other lane stays low. In the all-lane build, every lane carries the pattern. The memory array is not modelled, so reads in normal mode produce no beats from this block.

Top module: `mprReadout`

## Requirements
- R1: With the mode off (the reset state), READ and RDAP produce no beats, and no command raises `illegalCmd` except the malformed register 3 load of R11.
- R2: Command codes: 0 NOP, 1 READ, 2 RDAP, 3 WRITE, 4 LOAD MODE, 5 PRECHARGE, 6 REFRESH, 7 POWER-DOWN. The codes are qualified by `cmdValid`. A LOAD MODE with `bankAddr` = 3'b011 writes register 3. In that write, `addr[2]` = 1 turns the mode on, `addr[2]` = 0 turns it off, and `addr[1:0]` is stored as the pattern select.
- R3: Beat data is 0 on the first beat and then alternates 0,1,0,1. Beat 0 is the first in time and beat 7 the last.
- R4: With an 8-beat burst in force, a read with `addr[2]` = 0 yields exactly 8 consecutive valid beats. A read with `addr[2]` = 1 yields no beats.
- R5: With a fixed 4-beat chop (register 0 field `addr[1:0]` = 2'b10, loaded with `bankAddr` = 3'b000), a read yields 4 beats for either value of `addr[2]`, whatever the value of `addr[12]`.
- R6: With per-command selection (register 0 field = 2'b01), `addr[12]` = 0 chops the burst to 4 beats and `addr[12]` = 1 gives 8 beats, under the R4 rule on `addr[2]`.
- R7: A read whose `addr[1:0]` is not 00 yields no beats and raises no error.
- R8: With the mode on and a pattern select of 01, 10 or 11, reads yield no beats and raise no error.
- R9: The first beat is on the outputs READ_LAT clock edges after the edge that samples the read command. The remaining beats follow on consecutive cycles.
- R10: With the mode on, WRITE, PRECHARGE, REFRESH, POWER-DOWN and any LOAD MODE to register 0, 1 or 2 raise `illegalCmd` for one cycle, in the cycle after the command. The stored mode, select and burst settings stay unchanged.
- R11: A register 3 load with `bankAddr[2]` = 1 or any of `addr[13:3]` nonzero raises `illegalCmd`, in either mode, and is ignored.
- R12: In the prime-lane build (PRIME_ONLY = 1), only lanes whose index is a multiple of 8 carry the beat, and all others are 0. All DQ lanes are 0 whenever `dqValid` is low.
- R13: Reset returns the block to the mode-off state, with a pattern select of 00 and an 8-beat burst.
- R14: RDAP behaves exactly as READ. `bankAddr` and `addr[11:3]`, `addr[13]` (and `addr[12]` unless per-command selection is on) do not affect a readout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdType | input | 3 | Decoded command code (see R2) |
| bankAddr | input | 3 | Bank address bits |
| addr | input | 14 | Address bus bits 13:0 |
| dq | output | DQ_WIDTH | Per-beat data lanes |
| dqValid | output | 1 | High for each beat of a readout |
| illegalCmd | output | 1 | One-cycle pulse for a rejected command |

## Verification
The burst checks assume that reads are spaced at least one burst plus one idle cycle apart, so that one run of valid beats always belongs to exactly one read. The stimulus waits for each expected burst to drain, and then for one more idle cycle, before it issues the next command. The error-pulse check assumes that `cmdValid` lasts a single cycle per command. The driver raises `cmdValid` for exactly one clock each time.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int ADDR_W    = 14;
  localparam int BANK_W    = 3;
  localparam int CMD_W     = 3;
  localparam int BEAT_W    = 3;
  localparam int LONG_LEFT = 7;  // beats after the first in an 8-beat burst
  localparam int CHOP_LEFT = 3;  // beats after the first in a 4-beat chop

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 3'd0,
    CMD_READ = 3'd1,
    CMD_RDAP = 3'd2,
    CMD_WR   = 3'd3,
    CMD_LMR  = 3'd4,
    CMD_PRE  = 3'd5,
    CMD_REF  = 3'd6,
    CMD_PDN  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BURST_FIXED8 = 2'b00,
    BURST_OTF    = 2'b01,
    BURST_FIXED4 = 2'b10,
    BURST_RSVD   = 2'b11
  } burstMode_e;

  typedef struct packed {
    logic launch;     // start a pattern burst
    logic chop;       // 4 beats instead of 8
    logic upperHalf;  // first beat index is 4
  } burstStrobe_t;
endpackage

// File: rtl/mprCtrl.sv
module mprCtrl
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdType,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic [ADDR_W-1:0] addr,
  output burstStrobe_t      strobe,
  output logic              illegalCmd
);
  logic       mprEn;
  logic [1:0] mprSel;
  burstMode_e burstMode;

  cmd_e cmd;
  logic isRead, isLmr, toMr3, toMr0, mr3Clean, mr3Write, mr0Write;
  logic benign, badCmd, chopSel;

  always_comb begin
    cmd      = cmd_e'(cmdType);
    isRead   = cmdValid && (cmd == CMD_READ || cmd == CMD_RDAP);
    isLmr    = cmdValid && (cmd == CMD_LMR);
    toMr3    = isLmr && (bankAddr[1:0] == 2'b11);
    toMr0    = isLmr && (bankAddr == 3'b000);
    mr3Clean = (bankAddr[2] == 1'b0) && (addr[13:3] == '0);
    mr3Write = toMr3 && mr3Clean;
    mr0Write = toMr0 && !mprEn;
    benign   = !cmdValid || (cmd == CMD_NOP) || isRead;
    badCmd   = (toMr3 && !mr3Clean) || (mprEn && !benign && !mr3Write);

    unique case (burstMode)
      BURST_FIXED4: chopSel = 1'b1;
      BURST_OTF:    chopSel = !addr[12];
      default:      chopSel = 1'b0;
    endcase

    strobe.launch    = isRead && mprEn && (mprSel == 2'b00) &&
                       (addr[1:0] == 2'b00) && (chopSel || !addr[2]);
    strobe.chop      = chopSel;
    strobe.upperHalf = addr[2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mprEn      <= 1'b0;
      mprSel     <= 2'b00;
      burstMode  <= BURST_FIXED8;
      illegalCmd <= 1'b0;
    end else begin
      illegalCmd <= badCmd;
      if (mr3Write) begin
        mprEn  <= addr[2];
        mprSel <= addr[1:0];
      end
      if (mr0Write) burstMode <= burstMode_e'(addr[1:0]);
    end
  end
endmodule

// File: rtl/mprData.sv
module mprData
  import mpr_pkg::*;
#(
  parameter int DQ_WIDTH   = 16,
  parameter int READ_LAT   = 5,
  parameter bit PRIME_ONLY = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  burstStrobe_t        strobe,
  output logic [DQ_WIDTH-1:0] dq,
  output logic                dqValid
);
  localparam int PRIME_STRIDE = 8;

  burstStrobe_t pipe [READ_LAT];
  burstStrobe_t due;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < READ_LAT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= strobe;
      for (int i = 1; i < READ_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign due = pipe[READ_LAT-1];

  logic [BEAT_W-1:0] beatIdx;
  logic [BEAT_W-1:0] beatsLeft;
  logic              curBit;
  logic              validReg;
  logic [BEAT_W-1:0] startIdx;

  assign startIdx = {due.upperHalf, 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatIdx   <= '0;
      beatsLeft <= '0;
      curBit    <= 1'b0;
      validReg  <= 1'b0;
    end else if (due.launch) begin
      validReg  <= 1'b1;
      curBit    <= startIdx[0];
      beatIdx   <= startIdx + 3'd1;
      beatsLeft <= due.chop ? BEAT_W'(CHOP_LEFT) : BEAT_W'(LONG_LEFT);
    end else if (beatsLeft != '0) begin
      validReg  <= 1'b1;
      curBit    <= beatIdx[0];
      beatIdx   <= beatIdx + 3'd1;
      beatsLeft <= beatsLeft - 3'd1;
    end else begin
      validReg  <= 1'b0;
      curBit    <= 1'b0;
    end
  end

  assign dqValid = validReg;

  for (genvar g = 0; g < DQ_WIDTH; g++) begin : gLane
    if (!PRIME_ONLY || (g % PRIME_STRIDE == 0)) begin : gDrive
      assign dq[g] = curBit & validReg;
    end else begin : gLow
      assign dq[g] = 1'b0;
    end
  end
endmodule

// File: rtl/mprReadout.sv
module mprReadout
  import mpr_pkg::*;
#(
  parameter int DQ_WIDTH   = 16,
  parameter int READ_LAT   = 5,
  parameter bit PRIME_ONLY = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [2:0]          cmdType,
  input  logic [2:0]          bankAddr,
  input  logic [13:0]         addr,
  output logic [DQ_WIDTH-1:0] dq,
  output logic                dqValid,
  output logic                illegalCmd
);
  burstStrobe_t strobe;

  mprCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .bankAddr(bankAddr), .addr(addr), .strobe(strobe), .illegalCmd(illegalCmd)
  );

  mprData #(.DQ_WIDTH(DQ_WIDTH), .READ_LAT(READ_LAT), .PRIME_ONLY(PRIME_ONLY)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dq(dq), .dqValid(dqValid)
  );
endmodule

// File: rtl/mprReadoutChecker.sv
module mprReadoutChecker #(
  parameter int DQ_WIDTH   = 16,
  parameter bit PRIME_ONLY = 1'b1
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [DQ_WIDTH-1:0] dq,
  input logic                dqValid,
  input logic                illegalCmd
);
  logic [DQ_WIDTH-1:0] laneMask;
  logic [4:0]          runLen;

  always_comb begin
    for (int i = 0; i < DQ_WIDTH; i++) laneMask[i] = !PRIME_ONLY || (i % 8 == 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        runLen <= '0;
    else if (dqValid) runLen <= runLen + 5'd1;
    else              runLen <= '0;
  end

  AST_IDLE_LANES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !dqValid |-> (dq == '0)); // R12

  AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (dq & ~laneMask) == '0); // R12

  AST_FIRST_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqValid) |-> (dq == '0)); // R3

  AST_BEATS_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    (dqValid && $past(dqValid)) |-> (dq != $past(dq))); // R3

  AST_BURST_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqValid) |-> (runLen == 5'd4 || runLen == 5'd8)); // R4

  AST_ERROR_AFTER_CMD: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> $past(cmdValid)); // R10
endmodule

bind mprReadout mprReadoutChecker #(.DQ_WIDTH(DQ_WIDTH), .PRIME_ONLY(PRIME_ONLY)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .dq(dq),
  .dqValid(dqValid), .illegalCmd(illegalCmd)
);

// File: tb/mprReadout_test.sv
`timescale 1ns/1ps
module mprReadout_test;
  localparam int DQ_WIDTH = 16;
  localparam int READ_LAT = 5;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cmdValid = 1'b0;
  logic [2:0]          cmdType = 3'd0;
  logic [2:0]          bankAddr = 3'd0;
  logic [13:0]         addr = 14'd0;
  logic [DQ_WIDTH-1:0] dq;
  logic                dqValid;
  logic                illegalCmd;

  mprReadout #(.DQ_WIDTH(DQ_WIDTH), .READ_LAT(READ_LAT), .PRIME_ONLY(1'b1)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .bankAddr(bankAddr), .addr(addr), .dq(dq), .dqValid(dqValid), .illegalCmd(illegalCmd)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int                  cyc;
    logic [DQ_WIDTH-1:0] val;
    string               tag;
  } beat_t;

  beat_t  expQ[$];
  int     cyc = 0;
  int     checks = 0;
  int     fails = 0;
  int     validSeen = 0;
  logic [DQ_WIDTH-1:0] mask;

  initial for (int i = 0; i < DQ_WIDTH; i++) mask[i] = (i % 8 == 0);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected beats as the design produces them
  always @(negedge clk) begin
    if (rstN && dqValid) begin
      validSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R1 R7 R8", "unexpected beat", 1, 0);
      end else begin
        beat_t b;
        b = expQ.pop_front();
        check(cyc == b.cyc, b.tag, "beat cycle (R9)", cyc, b.cyc);
        check(dq == b.val, b.tag, "beat data", dq, b.val);
      end
    end
  end

  task automatic issue(input logic [2:0] t, input logic [2:0] ba, input logic [13:0] a,
                       input logic expIll, input string tag);
    cmdValid = 1'b1; cmdType = t; bankAddr = ba; addr = a;
    @(negedge clk);
    cmdValid = 1'b0; cmdType = 3'd0; bankAddr = 3'd0; addr = 14'd0;
    check(illegalCmd == expIll, tag, "illegalCmd", illegalCmd, expIll);
    @(negedge clk);
    check(illegalCmd == 1'b0, tag, "error pulse one cycle", illegalCmd, 0);
  endtask

  task automatic readExpect(input logic [2:0] t, input logic [2:0] ba, input logic [13:0] a,
                            input int nBeats, input string tag);
    int cNow;
    cNow = cyc;
    for (int i = 0; i < nBeats; i++) begin
      beat_t b;
      b.cyc = cNow + 1 + READ_LAT + i;
      b.val = (i % 2 == 1) ? mask : '0;
      b.tag = tag;
      expQ.push_back(b);
    end
    issue(t, ba, a, 1'b0, tag);
    repeat (nBeats + READ_LAT + 2) @(negedge clk);
    check(expQ.size() == 0, tag, "beats missing", expQ.size(), 0);
  endtask

  task automatic readNone(input logic [13:0] a, input string tag);
    int seen0;
    seen0 = validSeen;
    issue(3'd1, 3'd0, a, 1'b0, tag);
    repeat (READ_LAT + 10) @(negedge clk);
    check(validSeen == seen0, tag, "no readout", validSeen - seen0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dq == '0 && !dqValid && !illegalCmd, "R13", "outputs in reset", {dq, dqValid, illegalCmd}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // mode off
    readNone(14'h0000, "R1");
    issue(3'd3, 3'd0, 14'h0000, 1'b0, "R1");
    issue(3'd5, 3'd0, 14'h0000, 1'b0, "R1");

    // enable with pattern select 00
    issue(3'd4, 3'b011, 14'h0004, 1'b0, "R2");
    readExpect(3'd1, 3'd0, 14'h0000, 8, "R4");
    readExpect(3'd2, 3'b111, 14'h3FF8, 8, "R14");
    readNone(14'h0001, "R7");
    readNone(14'h0002, "R7");
    readNone(14'h0004, "R4");

    // illegal commands while mode on
    issue(3'd3, 3'd0, 14'h0000, 1'b1, "R10");
    issue(3'd5, 3'd0, 14'h0000, 1'b1, "R10");
    issue(3'd6, 3'd0, 14'h0000, 1'b1, "R10");
    issue(3'd7, 3'd0, 14'h0000, 1'b1, "R10");
    issue(3'd4, 3'b000, 14'h0002, 1'b1, "R10");
    issue(3'd4, 3'b001, 14'h0000, 1'b1, "R10");
    issue(3'd0, 3'd0, 14'h0000, 1'b0, "R10");
    readExpect(3'd1, 3'd0, 14'h0000, 8, "R10");

    // malformed register 3 loads
    issue(3'd4, 3'b011, 14'h0008, 1'b1, "R11");
    issue(3'd4, 3'b111, 14'h0000, 1'b1, "R11");
    readExpect(3'd1, 3'd0, 14'h0000, 8, "R11");

    // reserved pattern selects
    issue(3'd4, 3'b011, 14'h0005, 1'b0, "R8");
    readNone(14'h0000, "R8");
    issue(3'd4, 3'b011, 14'h0006, 1'b0, "R8");
    readNone(14'h0000, "R8");
    issue(3'd4, 3'b011, 14'h0007, 1'b0, "R8");
    readNone(14'h0000, "R8");

    // leave the mode
    issue(3'd4, 3'b011, 14'h0000, 1'b0, "R2");
    readNone(14'h0000, "R2");
    issue(3'd3, 3'd0, 14'h0000, 1'b0, "R2");
    issue(3'd4, 3'b011, 14'h200C, 1'b1, "R11");
    readNone(14'h0000, "R11");

    // fixed chop
    issue(3'd4, 3'b000, 14'h0002, 1'b0, "R5");
    issue(3'd4, 3'b011, 14'h0004, 1'b0, "R5");
    readExpect(3'd1, 3'd0, 14'h0000, 4, "R5");
    readExpect(3'd1, 3'd0, 14'h0004, 4, "R5");
    readExpect(3'd2, 3'd0, 14'h1000, 4, "R5");

    // per-command selection
    issue(3'd4, 3'b011, 14'h0000, 1'b0, "R6");
    issue(3'd4, 3'b000, 14'h0001, 1'b0, "R6");
    issue(3'd4, 3'b011, 14'h0004, 1'b0, "R6");
    readExpect(3'd1, 3'd0, 14'h0000, 4, "R6");
    readExpect(3'd1, 3'd0, 14'h1000, 8, "R6");
    readNone(14'h1004, "R6");
    readExpect(3'd1, 3'd0, 14'h0004, 4, "R6");

    // reset in the middle of the mode
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(!dqValid && !illegalCmd, "R13", "outputs in reset", {dqValid, illegalCmd}, 0);
    rstN = 1'b1;
    @(negedge clk);
    readNone(14'h0000, "R13");
    issue(3'd3, 3'd0, 14'h0000, 1'b0, "R13");
    issue(3'd4, 3'b011, 14'h0004, 1'b0, "R13");
    readExpect(3'd1, 3'd0, 14'h0000, 8, "R13");

    check(dq == '0, "R12", "lanes idle", dq, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule